// File: doc/BRIEF.md
# Fault Monitor Status Register

This block collects fault indications from a set of device monitors and holds them as active-low sticky flags in a status byte. A second status byte carries a conversion counter. The host reads both bytes and a small control byte through a simple register port. It writes the status byte to clear flags, and each flag follows its own clear rule.

The control byte holds two monitor enables and a header enable. When the header enable is set, the block captures both status bytes together at the start of each conversion data readout. It presents them as a 16-bit header that the serial engine sends ahead of the data. The serial engine reports each register write command to the block together with its outcome. A rejected command is dropped and recorded in a flag of its own.

Top module: `fault_status_reg`

## Requirements
- R1: After reset, the status byte (address 0) reads 0x7C: bit 7 (reset flag) is 0, bits 6..2 are 1, and bit 1 (data-ready) and bit 0 are 0. The counter byte (address 1) and the control byte (address 2) read 0x00. Address 3 always reads 0x00.
- R2: A fault input for the supply flag (bit 6), the reference flag (bit 5), the map-CRC flag (bit 4) or the memory flag (bit 3) sets that bit to 0 at the next clock edge. No conversion activity is needed.
- R3: The reference flag responds to its fault input only while control bit 0 is 1. The map-CRC flag responds only while control bit 1 is 1. The control byte in force before the edge applies.
- R4: An accepted write to address 0 returns to 1 each of bits 7..4 that is written as 1. Bits written as 0 are left as they are.
- R5: The memory flag (bit 3) ignores writes and returns to 1 only on reset.
- R6: Every register write command sets bit 2 to the inverse of its error input. A command with the error input set changes no other register.
- R7: The counter in address 1, bits 3..0, increments modulo 16 on each conversion-complete pulse. Bits 7..4 read 0, and writes to address 1 are ignored.
- R8: Data-ready (bit 1) goes to 1 on conversion complete and to 0 on a data-read start. When both happen in the same cycle, the bit ends at 1.
- R9: When a fault input and a clearing write reach the same flag in the same cycle, the flag ends at 0.
- R10: On a data-read start while control bit 2 is 1, the header output captures {status byte, counter byte} as they stood before that edge, and the header-valid output goes to 1. A data-read start while control bit 2 is 0 drives header-valid to 0 and leaves the header output unchanged. With no data-read start, the header output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flt_supply_i | input | 1 | Supply-undervoltage fault detect |
| flt_ref_i | input | 1 | Reference-undervoltage fault detect |
| flt_map_crc_i | input | 1 | Register-map CRC fault detect |
| flt_mem_i | input | 1 | Internal memory fault detect |
| wr_en_i | input | 1 | Register write command strobe |
| wr_err_i | input | 1 | Write command rejected by the bus engine |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data, combinational |
| conv_done_i | input | 1 | Conversion-complete pulse |
| data_rd_start_i | input | 1 | Start of a conversion data readout |
| header_o | output | 16 | Captured status header |
| header_vld_o | output | 1 | Header is to be sent with the current readout |

## Verification
A flag stuck low or high, or one with the wrong clear rule, appears in the status byte at the first read after the offending edge. The bench reads every address after every cycle, so such an error is seen within one clock. Counter or data-ready slips show up the same way, and they also reach the header at the next data-read start. A header captured late or early differs from the snapshot the bench takes before that edge.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;

  // status byte bit positions
  localparam int unsigned B_RST  = 7;
  localparam int unsigned B_SUP  = 6;
  localparam int unsigned B_REF  = 5;
  localparam int unsigned B_CRC  = 4;
  localparam int unsigned B_MEM  = 3;
  localparam int unsigned B_WF   = 2;
  localparam int unsigned B_DRDY = 1;

  localparam int unsigned N_W1C = 4;  // flags in bits 7..4

  typedef struct packed {
    logic hdr_en;
    logic crc_en;
    logic ref_en;
  } ctrl_t;
endpackage

// File: rtl/fsr_sticky_flag.sv
module fsr_sticky_flag #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_no <= RST_VAL;
    else if (set_i)  flag_no <= 1'b0;   // fault beats clear
    else if (clr_i)  flag_no <= 1'b1;
  end
endmodule

// File: rtl/fsr_conv.sv
module fsr_conv #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic             rd_start_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             drdy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      drdy_o <= 1'b0;
    end else begin
      if (done_i) cnt_o <= cnt_o + 1'b1;
      if (done_i)          drdy_o <= 1'b1;
      else if (rd_start_i) drdy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fsr_header.sv
module fsr_header #(
  parameter int unsigned HDR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             en_i,
  input  logic [HDR_W-1:0] snap_i,
  output logic [HDR_W-1:0] hdr_o,
  output logic             vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_o <= '0;
      vld_o <= 1'b0;
    end else if (start_i) begin
      vld_o <= en_i;
      if (en_i) hdr_o <= snap_i;
    end
  end
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
  import fsr_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned DW    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flt_supply_i,
  input  logic              flt_ref_i,
  input  logic              flt_map_crc_i,
  input  logic              flt_mem_i,
  input  logic              wr_en_i,
  input  logic              wr_err_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  input  logic              conv_done_i,
  input  logic              data_rd_start_i,
  output logic [2*DW-1:0]   header_o,
  output logic              header_vld_o
);
  localparam int unsigned HDR_W = 2 * DW;
  // index 0 is the reset flag, which comes up low
  localparam logic [N_W1C-1:0] W1C_RST = {{(N_W1C-1){1'b1}}, 1'b0};

  ctrl_t             ctrl_q;
  logic              wr_ok, stat_wr, ctrl_wr;
  logic [N_W1C-1:0]  w1c_set, w1c_clr, w1c_n;
  logic              mem_n, wf_n, drdy;
  logic [CNT_W-1:0]  cnt;
  logic [DW-1:0]     stat_byte, cnt_byte;

  assign wr_ok   = wr_en_i && !wr_err_i;
  assign stat_wr = wr_ok && (wr_addr_i == A_STAT);
  assign ctrl_wr = wr_ok && (wr_addr_i == A_CTRL);

  assign w1c_set = {flt_map_crc_i & ctrl_q.crc_en,
                    flt_ref_i     & ctrl_q.ref_en,
                    flt_supply_i,
                    1'b0};

  for (genvar i = 0; i < N_W1C; i++) begin : g_w1c
    assign w1c_clr[i] = stat_wr && wr_data_i[B_RST-i];
    fsr_sticky_flag #(.RST_VAL(W1C_RST[i])) u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (w1c_set[i]),
      .clr_i  (w1c_clr[i]),
      .flag_no(w1c_n[i])
    );
  end

  fsr_sticky_flag #(.RST_VAL(1'b1)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flt_mem_i),
    .clr_i  (1'b0),
    .flag_no(mem_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      wf_n   <= 1'b1;
    end else begin
      if (wr_en_i) wf_n   <= !wr_err_i;
      if (ctrl_wr) ctrl_q <= ctrl_t'(wr_data_i[$bits(ctrl_t)-1:0]);
    end
  end

  fsr_conv #(.CNT_W(CNT_W)) u_conv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (conv_done_i),
    .rd_start_i(data_rd_start_i),
    .cnt_o     (cnt),
    .drdy_o    (drdy)
  );

  always_comb begin
    stat_byte         = '0;
    stat_byte[B_RST]  = w1c_n[0];
    stat_byte[B_SUP]  = w1c_n[1];
    stat_byte[B_REF]  = w1c_n[2];
    stat_byte[B_CRC]  = w1c_n[3];
    stat_byte[B_MEM]  = mem_n;
    stat_byte[B_WF]   = wf_n;
    stat_byte[B_DRDY] = drdy;
    cnt_byte          = '0;
    cnt_byte[CNT_W-1:0] = cnt;
  end

  always_comb begin
    unique case (rd_addr_i)
      A_STAT:  rd_data_o = stat_byte;
      A_CNT:   rd_data_o = cnt_byte;
      A_CTRL:  rd_data_o = DW'(ctrl_q);
      default: rd_data_o = '0;
    endcase
  end

  fsr_header #(.HDR_W(HDR_W)) u_hdr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(data_rd_start_i),
    .en_i   (ctrl_q.hdr_en),
    .snap_i ({stat_byte, cnt_byte}),
    .hdr_o  (header_o),
    .vld_o  (header_vld_o)
  );
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned DW    = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            flt_supply_i,
  input logic            flt_ref_i,
  input logic            ref_en,
  input logic            stat_wr,
  input logic            clr_sup,
  input logic            sup_n,
  input logic            ref_n,
  input logic            mem_n,
  input logic            conv_done_i,
  input logic [CNT_W-1:0] cnt,
  input logic            data_rd_start_i,
  input logic [2*DW-1:0] header_o,
  input logic            wr_en_i,
  input logic            wr_err_i,
  input logic [DW-1:0]   stat_byte
);
  p_fault_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_supply_i |=> !sup_n);

  p_ref_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_en && ref_n) |=> ref_n);

  p_mem_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_n |=> !mem_n);

  p_wr_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_err_i) |=> !stat_byte[2]);

  p_cnt_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i |=> (cnt == $past(cnt) + 1'b1));

  p_fault_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_supply_i && stat_wr && clr_sup) |=> !sup_n);

  p_hdr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_rd_start_i |=> $stable(header_o));
endmodule

bind fault_status_reg fsr_checker #(.CNT_W(CNT_W), .DW(DW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .flt_supply_i   (flt_supply_i),
  .flt_ref_i      (flt_ref_i),
  .ref_en         (ctrl_q.ref_en),
  .stat_wr        (stat_wr),
  .clr_sup        (wr_data_i[6]),
  .sup_n          (w1c_n[1]),
  .ref_n          (w1c_n[2]),
  .mem_n          (mem_n),
  .conv_done_i    (conv_done_i),
  .cnt            (cnt),
  .data_rd_start_i(data_rd_start_i),
  .header_o       (header_o),
  .wr_en_i        (wr_en_i),
  .wr_err_i       (wr_err_i),
  .stat_byte      (stat_byte)
);

// File: tb/fault_status_reg_test.sv
module fault_status_reg_test;
  localparam int unsigned T_CLK = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       f_sup = 0, f_ref = 0, f_crc = 0, f_mem = 0;
  logic       wr_en = 0, wr_err = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic       conv = 0, rd_start = 0;
  logic [7:0] rd_data;
  logic [15:0] hdr;
  logic       hdr_vld;

  int nchk = 0, nerr = 0;
  bit done = 0;

  // reference model
  logic       m_rst, m_sup, m_ref, m_crc, m_mem, m_wf, m_drdy;
  logic [3:0] m_cnt;
  logic [2:0] m_ctrl;
  logic [15:0] m_hdr;
  logic       m_hvld;

  always #(T_CLK/2) clk = ~clk;

  fault_status_reg uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .flt_supply_i(f_sup), .flt_ref_i(f_ref), .flt_map_crc_i(f_crc), .flt_mem_i(f_mem),
    .wr_en_i(wr_en), .wr_err_i(wr_err), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .conv_done_i(conv), .data_rd_start_i(rd_start),
    .header_o(hdr), .header_vld_o(hdr_vld)
  );

  function automatic logic [7:0] exp_stat();
    return {m_rst, m_sup, m_ref, m_crc, m_mem, m_wf, m_drdy, 1'b0};
  endfunction

  function automatic logic [7:0] exp_cnt();
    return {4'h0, m_cnt};
  endfunction

  task automatic model_reset();
    m_rst = 0; m_sup = 1; m_ref = 1; m_crc = 1; m_mem = 1; m_wf = 1; m_drdy = 0;
    m_cnt = 0; m_ctrl = 0; m_hdr = 0; m_hvld = 0;
  endtask

  task automatic model_step();
    logic       ok;
    logic [7:0] clr;
    logic [15:0] snap;
    snap = {exp_stat(), exp_cnt()};
    ok  = wr_en && !wr_err;
    clr = (ok && wr_addr == 2'd0) ? wr_data : 8'h00;
    if (clr[7]) m_rst = 1;
    if (f_sup) m_sup = 0; else if (clr[6]) m_sup = 1;
    if (f_ref && m_ctrl[0]) m_ref = 0; else if (clr[5]) m_ref = 1;
    if (f_crc && m_ctrl[1]) m_crc = 0; else if (clr[4]) m_crc = 1;
    if (f_mem) m_mem = 0;
    if (wr_en) m_wf = !wr_err;
    if (rd_start) begin
      m_hvld = m_ctrl[2];
      if (m_ctrl[2]) m_hdr = snap;
    end
    if (ok && wr_addr == 2'd2) m_ctrl = wr_data[2:0];
    if (conv) m_cnt = m_cnt + 4'd1;
    if (conv) m_drdy = 1; else if (rd_start) m_drdy = 0;
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic verify(string tag);
    rd_addr = 2'd0; #1 chk({tag, " R2 R4 R5 R6 R8 stat"}, {8'h0, rd_data}, {8'h0, exp_stat()});
    rd_addr = 2'd1; #1 chk({tag, " R7 cnt"}, {8'h0, rd_data}, {8'h0, exp_cnt()});
    rd_addr = 2'd2; #1 chk({tag, " R3 ctrl"}, {8'h0, rd_data}, {13'h0, m_ctrl});
    rd_addr = 2'd3; #1 chk({tag, " R1 unused"}, {8'h0, rd_data}, 16'h0);
    chk({tag, " R10 hdr"}, hdr, m_hdr);
    chk({tag, " R10 hvld"}, {15'h0, hdr_vld}, {15'h0, m_hvld});
  endtask

  task automatic idle();
    f_sup = 0; f_ref = 0; f_crc = 0; f_mem = 0;
    wr_en = 0; wr_err = 0; wr_addr = 0; wr_data = 0; conv = 0; rd_start = 0;
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    idle();
    verify(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_ni = 0;
    #1 model_reset();
    verify("R1 reset");
    @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic host_wr(logic [1:0] a, logic [7:0] d, logic e);
    wr_en = 1; wr_addr = a; wr_data = d; wr_err = e;
  endtask

  initial begin
    #(T_CLK * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R1 exact reset value of status byte
    rd_addr = 2'd0; #1 chk("R1 reset byte", {8'h0, rd_data}, 16'h007C);

    // R3 gated monitors ignore faults while disabled
    f_ref = 1; f_crc = 1; tick("R3 gated");
    host_wr(2'd2, 8'h07, 0); tick("R3 enable");
    f_ref = 1; f_crc = 1; tick("R3 enabled fault");
    // R9 fault and clear same cycle
    f_sup = 1; host_wr(2'd0, 8'hF0, 0); tick("R9 collide");
    host_wr(2'd0, 8'hF0, 0); tick("R4 clear");
    // R5 memory flag ignores writes
    f_mem = 1; tick("R5 set");
    host_wr(2'd0, 8'hFF, 0); tick("R5 write");
    // R6 rejected write changes nothing else
    host_wr(2'd2, 8'h00, 1); tick("R6 err");
    host_wr(2'd1, 8'hFF, 0); tick("R7 ignored");
    // R7 wrap
    for (int i = 0; i < 17; i++) begin conv = 1; tick("R7 wrap"); end
    // R8 both in same cycle
    conv = 1; rd_start = 1; tick("R8 both");
    rd_start = 1; tick("R10 capture");
    host_wr(2'd2, 8'h00, 0); tick("R10 disable");
    rd_start = 1; tick("R10 off");

    // random phase
    for (int n = 0; n < 400; n++) begin
      f_sup = ($urandom % 10) == 0;
      f_ref = ($urandom % 8) == 0;
      f_crc = ($urandom % 8) == 0;
      f_mem = ($urandom % 40) == 0;
      if (($urandom % 3) == 0)
        host_wr(2'($urandom % 4), 8'($urandom), ($urandom % 5) == 0);
      conv     = ($urandom % 3) == 0;
      rd_start = ($urandom % 4) == 0;
      tick("rand");
      if (n == 200) do_reset();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule